// File: doc/BRIEF.md
# Indexed Byte-Port NVRAM Front End

This block lets a host reach a byte-addressed nonvolatile memory through a window of four byte-wide I/O ports. The host loads a 16-bit pointer one byte at a time (offset 0 sets the low byte, offset 1 sets the high byte). It then moves data through offset 3. A data write goes to the location the pointer names and then returns the pointer to zero. A data read returns the stored byte one cycle after the strobe and leaves the pointer alone.

Two 16-byte windows, one at 0x20 and one at 0x30, can each be made inaccessible. A pulse on that window's toggle input flips its protection bit. While a window is protected, writes into it are dropped and reads from it return 0xFF. Any location at or beyond the memory size parameter is handled as unmapped: writes are dropped and reads return 0xFF. The memory array itself sits outside the block and is reached through a byte port with a combinational read path.

Top module: `nvport_front`

## Requirements
- R1: After reset the pointer (seen on `memAddr`) is 0x0000, both protection bits are clear, and `portRdData` is 0xFF.
- R2: A port write at offset 0 replaces pointer bits 7:0 with the written byte. Bits 15:8 keep their value.
- R3: A port write at offset 1 replaces pointer bits 15:8 with the written byte. Bits 7:0 keep their value.
- R4: A port write at offset 3 to an allowed location asserts `memWrEn` in that cycle, with `memAddr` at the pointer and `memWrData` equal to the written byte. After that edge the pointer is 0x0000.
- R5: A port read at offset 3 of an allowed location loads `portRdData` at the next edge with the byte the memory returns for the pointer. The read does not change the pointer.
- R6: While protection bit 0 is set, locations 0x20 to 0x2F raise no `memWrEn`, and data reads of them return 0xFF. A data write to such a location still clears the pointer.
- R7: While protection bit 1 is set, locations 0x30 to 0x3F behave the same way as in R6.
- R8: A one-cycle pulse on `lockToggle[i]` inverts protection bit i. It does not set the bit to a fixed value.
- R9: Locations at or above MEM_SIZE (default 8192) never raise `memWrEn` or `memRdEn`. Data reads of them return 0xFF. A data write to such a location still clears the pointer.
- R10: Port reads at offsets 0, 1 and 2 return 0xFF at the next edge. A port write at offset 2 leaves the pointer unchanged and raises no memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| portOfs | input | 2 | Offset of the access within the port window |
| portWr | input | 1 | Port write strobe |
| portRd | input | 1 | Port read strobe |
| portWrData | input | 8 | Byte written by the host |
| portRdData | output | 8 | Byte returned to the host, registered |
| lockToggle | input | 2 | One-cycle pulses that flip the protection bits |
| memAddr | output | 16 | Current pointer, sent to the memory |
| memWrEn | output | 1 | Memory write strobe |
| memWrData | output | 8 | Memory write byte |
| memRdEn | output | 1 | Memory read strobe |
| memRdData | input | 8 | Memory read byte, valid in the same cycle as memAddr |

## Verification
A corrupted pointer is visible on `memAddr` in the cycle right after the edge that caused it. The per-cycle comparison therefore catches a wrong byte lane or a missed auto-clear at once. A protection bit that drifts stays hidden until an access hits its window. The bench therefore follows every toggle with writes and reads inside and just outside each window; a stuck or inverted bit then shows as a stray `memWrEn` or as a wrong `portRdData` one edge later. Range and offset decode errors show up in the same cycle as a memory strobe that should not be there.

// File: rtl/nvport_pkg.sv
package nvport_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic ldLo;     // replace pointer low byte
    logic ldHi;     // replace pointer high byte
    logic clrAddr;  // return pointer to zero
    logic memWr;    // forward write to memory
    logic rdCap;    // capture a read result
    logic rdPass;   // read result comes from memory
  } ctrlStb_t;
endpackage

// File: rtl/nvport_ctrl.sv
module nvport_ctrl
  import nvport_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int MEM_SIZE  = 8192,
  parameter int LOCK_BASE = 32,
  parameter int LOCK_SPAN = 16,
  parameter int NUM_LOCKS = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           portOfs,
  input  logic                 portWr,
  input  logic                 portRd,
  input  logic [NUM_LOCKS-1:0] lockToggle,
  input  logic [ADDR_W-1:0]    addr,
  output logic [NUM_LOCKS-1:0] lockState,
  output ctrlStb_t             stb
);
  localparam logic [1:0] OFS_LO   = 2'd0;
  localparam logic [1:0] OFS_HI   = 2'd1;
  localparam logic [1:0] OFS_DATA = 2'd3;

  logic [NUM_LOCKS-1:0] lockQ;
  logic [NUM_LOCKS-1:0] lockHit;
  logic [31:0]          addrWide;
  logic                 inRange;
  logic                 allowed;

  assign addrWide = 32'(addr);
  assign inRange  = addrWide < 32'(MEM_SIZE);

  for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_lock
    localparam int WIN_LO = LOCK_BASE + i * LOCK_SPAN;
    assign lockHit[i] = lockQ[i] && (addrWide >= 32'(WIN_LO)) &&
                        (addrWide < 32'(WIN_LO + LOCK_SPAN));
  end

  assign allowed = inRange && (lockHit == '0);

  always_ff @(posedge clk) begin
    if (!rstN) lockQ <= '0;
    else       lockQ <= lockQ ^ lockToggle;
  end

  assign lockState = lockQ;

  always_comb begin
    stb         = '0;
    stb.ldLo    = portWr && (portOfs == OFS_LO);
    stb.ldHi    = portWr && (portOfs == OFS_HI);
    stb.clrAddr = portWr && (portOfs == OFS_DATA);
    stb.memWr   = stb.clrAddr && allowed;
    stb.rdCap   = portRd;
    stb.rdPass  = portRd && (portOfs == OFS_DATA) && allowed;
  end
endmodule

// File: rtl/nvport_dpath.sv
module nvport_dpath
  import nvport_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStb_t          stb,
  input  logic [DATA_W-1:0] portWrData,
  input  logic [DATA_W-1:0] memRdData,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] portRdData,
  output logic              memWrEn,
  output logic [DATA_W-1:0] memWrData,
  output logic              memRdEn
);
  localparam int HI_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] rdQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
    end else if (stb.clrAddr) begin
      addrQ <= '0;
    end else if (stb.ldLo) begin
      addrQ[DATA_W-1:0] <= portWrData;
    end else if (stb.ldHi) begin
      addrQ[ADDR_W-1:DATA_W] <= portWrData[HI_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)          rdQ <= '1;
    else if (stb.rdCap) rdQ <= stb.rdPass ? memRdData : '1;
  end

  assign addr       = addrQ;
  assign portRdData = rdQ;
  assign memWrEn    = stb.memWr;
  assign memWrData  = portWrData;
  assign memRdEn    = stb.rdPass;
endmodule

// File: rtl/nvport_front.sv
module nvport_front
  import nvport_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int MEM_SIZE  = 8192,
  parameter int LOCK_BASE = 32,
  parameter int LOCK_SPAN = 16,
  parameter int NUM_LOCKS = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           portOfs,
  input  logic                 portWr,
  input  logic                 portRd,
  input  logic [DATA_W-1:0]    portWrData,
  output logic [DATA_W-1:0]    portRdData,
  input  logic [NUM_LOCKS-1:0] lockToggle,
  output logic [ADDR_W-1:0]    memAddr,
  output logic                 memWrEn,
  output logic [DATA_W-1:0]    memWrData,
  output logic                 memRdEn,
  input  logic [DATA_W-1:0]    memRdData
);
  ctrlStb_t             stb;
  logic [NUM_LOCKS-1:0] lockState;

  nvport_ctrl #(
    .ADDR_W(ADDR_W), .MEM_SIZE(MEM_SIZE), .LOCK_BASE(LOCK_BASE),
    .LOCK_SPAN(LOCK_SPAN), .NUM_LOCKS(NUM_LOCKS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .portOfs(portOfs), .portWr(portWr),
    .portRd(portRd), .lockToggle(lockToggle), .addr(memAddr),
    .lockState(lockState), .stb(stb)
  );

  nvport_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .portWrData(portWrData),
    .memRdData(memRdData), .addr(memAddr), .portRdData(portRdData),
    .memWrEn(memWrEn), .memWrData(memWrData), .memRdEn(memRdEn)
  );
endmodule

// File: rtl/nvport_front_chk.sv
module nvport_front_chk #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int MEM_SIZE  = 8192,
  parameter int LOCK_BASE = 32,
  parameter int LOCK_SPAN = 16,
  parameter int NUM_LOCKS = 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [1:0]           portOfs,
  input logic                 portWr,
  input logic                 portRd,
  input logic [DATA_W-1:0]    portWrData,
  input logic [DATA_W-1:0]    portRdData,
  input logic [NUM_LOCKS-1:0] lockToggle,
  input logic [NUM_LOCKS-1:0] lockState,
  input logic [ADDR_W-1:0]    memAddr,
  input logic                 memWrEn,
  input logic                 memRdEn,
  input logic [DATA_W-1:0]    memRdData
);
  logic [31:0] aw;
  logic        inWin0, inWin1;
  assign aw     = 32'(memAddr);
  assign inWin0 = aw >= 32'(LOCK_BASE) && aw < 32'(LOCK_BASE + LOCK_SPAN);
  assign inWin1 = aw >= 32'(LOCK_BASE + LOCK_SPAN) &&
                  aw < 32'(LOCK_BASE + 2 * LOCK_SPAN);

  p_lo_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    (portWr && portOfs == 2'd0) |=>
      (memAddr[DATA_W-1:0] == $past(portWrData)) &&
      (memAddr[ADDR_W-1:DATA_W] == $past(memAddr[ADDR_W-1:DATA_W])));

  p_hi_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    (portWr && portOfs == 2'd1) |=>
      (memAddr[DATA_W-1:0] == $past(memAddr[DATA_W-1:0])));

  p_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    (portWr && portOfs == 2'd3) |=> (memAddr == '0));

  p_read_r5: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> (portRdData == $past(memRdData)) && $stable(memAddr));

  p_win0_r6: assert property (@(posedge clk) disable iff (!rstN)
    (lockState[0] && inWin0) |-> !(memWrEn || memRdEn));

  p_win1_r7: assert property (@(posedge clk) disable iff (!rstN)
    (lockState[1] && inWin1) |-> !(memWrEn || memRdEn));

  p_toggle_r8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> lockState == ($past(lockState) ^ $past(lockToggle)));

  p_range_r9: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn || memRdEn) |-> aw < 32'(MEM_SIZE));

  p_ofs_r10: assert property (@(posedge clk) disable iff (!rstN)
    (portRd && portOfs != 2'd3) |=> portRdData == '1);
endmodule

bind nvport_front nvport_front_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MEM_SIZE(MEM_SIZE),
  .LOCK_BASE(LOCK_BASE), .LOCK_SPAN(LOCK_SPAN), .NUM_LOCKS(NUM_LOCKS)
) u_chk (
  .clk(clk), .rstN(rstN), .portOfs(portOfs), .portWr(portWr),
  .portRd(portRd), .portWrData(portWrData), .portRdData(portRdData),
  .lockToggle(lockToggle), .lockState(lockState), .memAddr(memAddr),
  .memWrEn(memWrEn), .memRdEn(memRdEn), .memRdData(memRdData)
);

// File: tb/nvport_front_bench.sv
module nvport_front_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] portOfs = '0;
  logic       portWr = 1'b0, portRd = 1'b0;
  logic [7:0] portWrData = '0;
  logic [7:0] portRdData;
  logic [1:0] lockToggle = '0;
  logic [15:0] memAddr;
  logic       memWrEn, memRdEn;
  logic [7:0] memWrData, memRdData;

  int nCmp = 0, nBad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  nvport_front u_nvport_front (
    .clk(clk), .rstN(rstN), .portOfs(portOfs), .portWr(portWr),
    .portRd(portRd), .portWrData(portWrData), .portRdData(portRdData),
    .lockToggle(lockToggle), .memAddr(memAddr), .memWrEn(memWrEn),
    .memWrData(memWrData), .memRdEn(memRdEn), .memRdData(memRdData)
  );

  // downstream memory, 8 KiB
  logic [7:0] ram [0:8191];
  assign memRdData = ram[memAddr[12:0]];
  always @(posedge clk) if (memWrEn) ram[memAddr[12:0]] <= memWrData;

  // reference model state
  int   refAddr = 0;
  int   refRd = 255;
  bit   refLock [2];
  byte  refRam [int];

  function automatic int initByte(int a);
    return (a * 7 + 3) & 255;
  endfunction

  function automatic int refByte(int a);
    return refRam.exists(a) ? (int'(refRam[a]) & 255) : initByte(a);
  endfunction

  function automatic bit allowedAt(int a);
    if (a >= 8192) return 0;
    if (refLock[0] && a >= 32 && a < 48) return 0;
    if (refLock[1] && a >= 48 && a < 64) return 0;
    return 1;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // one bus cycle: drive after a falling edge, compare before and after the rising edge
  task automatic cyc(string tag, bit wr, bit rd, int ofs, int data, int tog);
    bit ok;
    portWr = wr; portRd = rd; portOfs = 2'(ofs);
    portWrData = 8'(data); lockToggle = 2'(tog);
    #1;
    ok = allowedAt(refAddr);
    check(tag, "memAddr", int'(memAddr), refAddr);
    check(tag, "memWrEn", int'(memWrEn), int'(wr && ofs == 3 && ok));
    check(tag, "memRdEn", int'(memRdEn), int'(rd && ofs == 3 && ok));
    @(posedge clk);
    if (rd) refRd = (ofs == 3 && ok) ? refByte(refAddr) : 255;
    if (wr) begin
      if (ofs == 0) refAddr = (refAddr & 'hFF00) | (data & 255);
      else if (ofs == 1) refAddr = (refAddr & 'h00FF) | ((data & 255) << 8);
      else if (ofs == 3) begin
        if (ok) refRam[refAddr] = byte'(data);
        refAddr = 0;
      end
    end
    if (tog[0]) refLock[0] = !refLock[0];
    if (tog[1]) refLock[1] = !refLock[1];
    @(negedge clk);
    portWr = 0; portRd = 0; lockToggle = '0;
    check(tag, "portRdData", int'(portRdData), refRd);
    check(tag, "memAddr after edge", int'(memAddr), refAddr);
  endtask

  task automatic setAddr(string tag, int a);
    cyc(tag, 1, 0, 0, a & 255, 0);
    cyc(tag, 1, 0, 1, (a >> 8) & 255, 0);
  endtask

  initial begin
    #2_000_000;
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8192; i++) ram[i] = 8'(initByte(i));
    refLock[0] = 0; refLock[1] = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: reset state
    check("R1", "memAddr", int'(memAddr), 0);
    check("R1", "portRdData", int'(portRdData), 255);
    cyc("R1", 0, 1, 3, 0, 0);            // read at 0 unlocked

    // R2 / R3: pointer byte loading
    cyc("R2", 1, 0, 0, 'h45, 0);
    cyc("R3", 1, 0, 1, 'h12, 0);
    cyc("R2", 1, 0, 0, 'h67, 0);
    cyc("R5", 0, 1, 3, 0, 0);            // R5 read keeps pointer
    // R4: write then auto-clear
    cyc("R4", 1, 0, 3, 'hA5, 0);
    setAddr("R4", 'h1267);
    cyc("R4", 0, 1, 3, 0, 0);

    // R10: non-data offsets
    cyc("R10", 0, 1, 0, 0, 0);
    cyc("R10", 0, 1, 1, 0, 0);
    cyc("R10", 0, 1, 2, 0, 0);
    cyc("R10", 1, 0, 2, 'h99, 0);

    // R6: window 0
    cyc("R8", 0, 0, 0, 0, 1);
    setAddr("R6", 'h25);
    cyc("R6", 0, 1, 3, 0, 0);
    cyc("R6", 1, 0, 3, 'h3C, 0);
    setAddr("R6", 'h1F);
    cyc("R6", 1, 0, 3, 'h11, 0);
    setAddr("R6", 'h30);
    cyc("R6", 1, 0, 3, 'h22, 0);
    cyc("R8", 0, 0, 0, 0, 1);            // toggle back: unlock
    setAddr("R8", 'h25);
    cyc("R8", 0, 1, 3, 0, 0);

    // R7: window 1
    cyc("R7", 0, 0, 0, 0, 2);
    setAddr("R7", 'h3A);
    cyc("R7", 0, 1, 3, 0, 0);
    cyc("R7", 1, 0, 3, 'h77, 0);
    setAddr("R7", 'h2F);
    cyc("R7", 0, 1, 3, 0, 0);
    cyc("R8", 0, 0, 0, 0, 3);            // lock 0 on, lock 1 off
    setAddr("R8", 'h3A);
    cyc("R8", 0, 1, 3, 0, 0);
    setAddr("R8", 'h2A);
    cyc("R8", 0, 1, 3, 0, 0);
    cyc("R8", 0, 0, 0, 0, 1);

    // R9: beyond memory size
    setAddr("R9", 'h2000);
    cyc("R9", 0, 1, 3, 0, 0);
    cyc("R9", 1, 0, 3, 'h55, 0);
    setAddr("R9", 'hFFFF);
    cyc("R9", 0, 1, 3, 0, 0);
    setAddr("R9", 'h1FFF);
    cyc("R9", 1, 0, 3, 'h5A, 0);
    setAddr("R9", 'h1FFF);
    cyc("R9", 0, 1, 3, 0, 0);

    // R5: mixed traffic
    for (int i = 0; i < 400; i++) begin
      int op, ofs, d, hiSel;
      op = int'($urandom_range(0, 2));
      ofs = int'($urandom_range(0, 3));
      d = int'($urandom_range(0, 255));
      hiSel = int'($urandom_range(0, 3));
      if (ofs == 1) d = (hiSel == 0) ? 0 : (hiSel == 1) ? 'h1F : (hiSel == 2) ? 'h20 : d;
      cyc("R5", op == 1, op == 2, ofs, d, int'($urandom_range(0, 7)) == 0 ? 1 : 0);
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule